// File: doc/BRIEF.md
# Serial Character Transmitter with Sixteenth-Bit Stop Control

This block serialises one character at a time onto an asynchronous line that idles high. A free-running enable pulse, `tick16`, arrives sixteen times per bit period and sets the bit timing. The block is also given the character length, the parity mode and a four-bit stop-length code. Each character is framed with a low start bit, followed by 5 to 8 data bits sent least significant bit first, then an optional parity slot, then a stop period. The stop period can be set in steps of one sixteenth of a bit.

A single holding register takes the character from the host side, and a shift stage drives the line. The transmitter can be switched on and off by command pulses, and writes made while it is off are dropped. Optionally, a character may start only while the clear-to-send input is high. The request-to-send output can also be dropped automatically once both stages have drained. The `tx_rdy` and `tx_emt` outputs report the state of the holding register and of the whole transmitter.

Top module: `uart_tx_fracstop`

## Requirements
- R1: After reset, `txd`=1, `tx_rdy`=0 (the transmitter starts disabled), `tx_emt`=1 and `rts`=0.
- R2: A character is sent as one start bit at 0, then (5 + `len_code`) data bits LSB first. Length codes are 0=5, 1=6, 2=7, 3=8 bits. The start bit and each data bit last exactly 16 `tick16` pulses. The start bit begins on the first tick at which the character is both held and allowed to start.
- R3: The `par_mode` input selects what follows the data. 0 sends a parity bit equal to the XOR of the data bits XOR `par_odd` (`par_odd`=0 gives even parity, 1 gives odd). 1 sends `par_odd` as a constant bit. 2 sends no parity slot. 3 sends `par_odd` as an address/data flag. The parity slot lasts 16 ticks.
- R4: The stop period is high. A `stop_code` n from 8 to 15 gives 17+n ticks. A code n from 0 to 7 gives 9+n ticks.
- R5: With 5-bit characters (`len_code`=0), stop codes 0 to 7 last 8 ticks longer (17+n). Codes 8 to 15 are unchanged.
- R6: While `cts_ctl`=1, a held character does not start while `cts`=0. `txd` stays high and `tx_emt` stays 0. The character starts on the first tick after `cts` goes high.
- R7: A `rts_set` pulse drives `rts` high. While `rts_ctl`=1, `rts` falls once the transmitter becomes empty. While `rts_ctl`=0, `rts` stays high.
- R8: While the transmitter is disabled, `wr_valid` has no effect: `tx_emt` stays 1 and nothing is sent.
- R9: If `tx_dis` is pulsed during a character, that character completes in full and the line then stays high.
- R10: `tx_rdy` is 1 exactly when the transmitter is enabled and the holding register is free. `tx_emt` is 1 exactly when both the holding and shift stages are empty.
- R11: If a second character is waiting when a stop period ends, its start bit follows on the very next tick period, with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Enable pulse, 16 per bit period |
| tx_en | input | 1 | Enable command pulse |
| tx_dis | input | 1 | Disable command pulse (wins over tx_en) |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| len_code | input | 2 | Data bits minus 5 |
| par_mode | input | 2 | 0 parity, 1 forced, 2 none, 3 address flag |
| par_odd | input | 1 | Parity sense or constant bit value |
| stop_code | input | 4 | Stop length code |
| cts_ctl | input | 1 | Gate starts on cts |
| cts | input | 1 | Clear-to-send, high = asserted |
| rts_ctl | input | 1 | Drop rts automatically when empty |
| rts_set | input | 1 | Pulse to raise rts |
| txd | output | 1 | Serial line |
| tx_rdy | output | 1 | Holding register can accept a character |
| tx_emt | output | 1 | Holding and shift stages both empty |
| rts | output | 1 | Request-to-send |

## Verification
The bench records the line level in every tick period and compares it against a model of whole frames. A shortened or stretched bit, a stop code off by one step, or a missing half-bit extension for 5-bit characters therefore shows up as a shifted edge. Back-to-back pairs catch a design that inserts an idle tick between frames or reloads the holding register too late. Directed cases target three behaviours. Writes during disable must leave `tx_emt` high, so a design that loads anyway would clear it. A disable in mid-frame must still deliver the whole frame, so truncating it would cut the sequence. With CTS gating on, starting early would show a low level before `cts` rises.

// File: rtl/uart_tx_fracstop.sv
module uart_tx_fracstop (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       tx_en,
  input  logic       tx_dis,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  input  logic [1:0] len_code,
  input  logic [1:0] par_mode,
  input  logic       par_odd,
  input  logic [3:0] stop_code,
  input  logic       cts_ctl,
  input  logic       cts,
  input  logic       rts_ctl,
  input  logic       rts_set,
  output logic       txd,
  output logic       tx_rdy,
  output logic       tx_emt,
  output logic       rts
);

  logic       en_q, hold_full, busy, stop_ph, emt_q, rts_q;
  logic [7:0] hold_d;
  logic [9:0] frame, frame_nx;
  logic [3:0] idx, last_idx, last_nx, nd;
  logic [4:0] sub;
  logic [5:0] stop_len, stop_nx;
  logic       pbit, cts_ok, done, start, wr_ok;
  logic [7:0] dm;

  assign cts_ok = !cts_ctl || cts;
  assign done   = tick16 && busy && stop_ph && ({1'b0, sub} == stop_len - 6'd1);
  assign start  = tick16 && hold_full && en_q && cts_ok && (!busy || done);
  assign wr_ok  = wr_valid && en_q && !hold_full;
  assign nd     = 4'd5 + {2'b00, len_code};

  always_comb begin
    for (int i = 0; i < 8; i++) dm[i] = (i < int'(nd)) ? hold_d[i] : 1'b0;
    pbit = (par_mode == 2'd0) ? (^dm ^ par_odd) : par_odd;
    frame_nx = '1;
    frame_nx[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < int'(nd)) frame_nx[i+1] = hold_d[i];
    if (par_mode != 2'd2) frame_nx[nd+4'd1] = pbit;
    last_nx = nd + ((par_mode != 2'd2) ? 4'd1 : 4'd0);
    if (stop_code[3]) stop_nx = 6'd17 + {2'b00, stop_code};
    else              stop_nx = 6'd9 + {2'b00, stop_code} + ((len_code == 2'd0) ? 6'd8 : 6'd0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      hold_full <= 1'b0;
      hold_d    <= '0;
    end else begin
      if (tx_dis)     en_q <= 1'b0;
      else if (tx_en) en_q <= 1'b1;
      if (start) hold_full <= 1'b0;
      else if (wr_ok) begin
        hold_full <= 1'b1;
        hold_d    <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; stop_ph <= 1'b0; idx <= '0; sub <= '0;
      frame <= '1; last_idx <= '0; stop_len <= 6'd16;
    end else if (start) begin
      busy <= 1'b1; stop_ph <= 1'b0; idx <= '0; sub <= '0;
      frame <= frame_nx; last_idx <= last_nx; stop_len <= stop_nx;
    end else if (done) begin
      busy <= 1'b0; stop_ph <= 1'b0;
    end else if (tick16 && busy) begin
      if (stop_ph) sub <= sub + 5'd1;
      else if (sub == 5'd15) begin
        sub <= '0;
        if (idx == last_idx) stop_ph <= 1'b1;
        else                 idx <= idx + 4'd1;
      end else sub <= sub + 5'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      emt_q <= 1'b1;
      rts_q <= 1'b0;
    end else begin
      emt_q <= tx_emt;
      if (rts_set) rts_q <= 1'b1;
      else if (rts_ctl && tx_emt && !emt_q) rts_q <= 1'b0;
    end
  end

  assign txd    = !(busy && !stop_ph) || frame[idx];
  assign tx_rdy = en_q && !hold_full;
  assign tx_emt = !hold_full && !busy;
  assign rts    = rts_q;

  // R10
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n) tx_emt |-> txd);
  // R8
  no_load_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !en_q && !hold_full) |=> !hold_full);
  // R6
  cts_gated_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!cts_ctl || cts));
  // R4
  stop_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stop_ph) |-> ({1'b0, sub} < stop_len));
  // R7
  rts_auto_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_ctl && tx_emt && !emt_q && !rts_set) |=> !rts);

endmodule

// File: tb/sim_uart_tx_fracstop.sv
module sim_uart_tx_fracstop;
  logic clk = 0, rst_n = 0, tick16 = 0;
  logic tx_en = 0, tx_dis = 0, wr_valid = 0, par_odd = 0;
  logic cts_ctl = 0, cts = 0, rts_ctl = 0, rts_set = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] len_code = 3, par_mode = 2;
  logic [3:0] stop_code = 7;
  logic txd, tx_rdy, tx_emt, rts;

  int checks = 0, fails = 0;
  logic exp_lv [0:511];
  int exp_n = 0;
  int tcnt = 0;

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    tcnt   <= (tcnt == 3) ? 0 : tcnt + 1;
    tick16 <= (tcnt == 3);
  end

  uart_tx_fracstop u0 (.*);

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_valid = 1; wr_data = d;
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic next_level(output logic l);
    @(posedge clk iff tick16);
    @(negedge clk);
    l = txd;
  endtask

  task automatic push(logic v, int n);
    for (int i = 0; i < n; i++) begin exp_lv[exp_n] = v; exp_n++; end
  endtask

  task automatic add_frame(logic [7:0] d);
    int nd;
    logic p;
    nd = 5 + len_code;
    push(0, 16);
    for (int i = 0; i < nd; i++) push(d[i], 16);
    p = par_odd;
    if (par_mode == 0) begin
      for (int i = 0; i < nd; i++) p ^= d[i];
    end
    if (par_mode != 2) push(p, 16);
    if (stop_code >= 8) push(1, 17 + stop_code);
    else push(1, 9 + stop_code + ((len_code == 0) ? 8 : 0));
  endtask

  task automatic capture(string req, int extra);
    logic l;
    int bad = -1;
    logic a = 0, e = 0;
    push(1, extra);
    for (int i = 0; i < exp_n; i++) begin
      next_level(l);
      if (l !== exp_lv[i] && bad < 0) begin bad = i; a = l; e = exp_lv[i]; end
    end
    checks++;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s tick %0d actual=%0b expected=%0b", req, bad, a, e);
    end
    exp_n = 0;
  endtask

  task automatic pair(logic [7:0] a, logic [7:0] b, string req);
    exp_n = 0;
    add_frame(a); add_frame(b);
    wr(a);
    fork
      capture(req, 4);
      begin
        while (!tx_rdy) @(negedge clk);
        wr(b);
        chk("R10 busy flags emt", tx_emt, 0);
        chk("R10 holding full rdy", tx_rdy, 0);
      end
    join
    chk("R10 drained emt", tx_emt, 1);
    chk("R10 drained rdy", tx_rdy, 1);
  endtask

  initial begin
    logic l;
    void'($urandom(32'd4242));
    fork
      begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    join_none

    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 txd", txd, 1); chk("R1 tx_rdy", tx_rdy, 0);
    chk("R1 tx_emt", tx_emt, 1); chk("R1 rts", rts, 0);

    // R8: writes while disabled
    wr(8'h00);
    for (int i = 0; i < 40; i++) begin
      next_level(l);
      if (l !== 1) begin chk("R8 line idle", l, 1); break; end
    end
    chk("R8 no load emt", tx_emt, 1);
    chk("R8 rdy low", tx_rdy, 0);
    pulse(tx_en);
    @(negedge clk);
    chk("R8 still empty after enable", tx_emt, 1);
    chk("R10 rdy enabled", tx_rdy, 1);

    // R2 R4 directed
    len_code = 3; par_mode = 2; stop_code = 7;
    pair(8'hA5, 8'h3C, "R2 R11 8N stop16");
    len_code = 0; stop_code = 0;
    pair(8'h15, 8'h0A, "R5 5-bit code0");
    len_code = 0; stop_code = 8;
    pair(8'h1F, 8'h01, "R5 5-bit code8");
    len_code = 2; par_mode = 0; par_odd = 0; stop_code = 15;
    pair(8'h6B, 8'h01, "R3 even R4 code15");
    len_code = 1; par_mode = 0; par_odd = 1; stop_code = 3;
    pair(8'h2A, 8'h3F, "R3 odd R4 code3");
    len_code = 3; par_mode = 1; par_odd = 1; stop_code = 9;
    pair(8'hFF, 8'h00, "R3 forced");
    par_mode = 3; par_odd = 0; stop_code = 0;
    pair(8'h81, 8'h7E, "R3 wake flag");

    // random pairs
    for (int k = 0; k < 16; k++) begin
      len_code = 2'($urandom_range(0, 3));
      par_mode = 2'($urandom_range(0, 3));
      par_odd = 1'($urandom_range(0, 1));
      stop_code = 4'($urandom_range(0, 15));
      pair(8'($urandom), 8'($urandom), "R2 R3 R4 R11 random");
    end

    // R6 CTS gating
    len_code = 3; par_mode = 2; stop_code = 7;
    cts_ctl = 1; cts = 0;
    wr(8'h55);
    for (int i = 0; i < 24; i++) begin
      next_level(l);
      if (l !== 1) begin chk("R6 held by cts", l, 1); break; end
    end
    chk("R6 not empty while held", tx_emt, 0);
    exp_n = 0; add_frame(8'h55);
    @(negedge clk); cts = 1;
    capture("R6 start after cts", 2);
    cts_ctl = 0;

    // R7 RTS
    rts_ctl = 1;
    pulse(rts_set);
    @(negedge clk);
    chk("R7 rts raised", rts, 1);
    exp_n = 0; add_frame(8'h12);
    wr(8'h12);
    chk("R7 rts held in frame", rts, 1);
    capture("R7 frame", 2);
    chk("R7 rts dropped", rts, 0);
    rts_ctl = 0;
    pulse(rts_set);
    exp_n = 0; add_frame(8'h34);
    wr(8'h34);
    capture("R7 frame no auto", 2);
    chk("R7 rts kept", rts, 1);

    // R9 disable mid-char
    exp_n = 0; add_frame(8'hC3);
    wr(8'hC3);
    fork
      capture("R9 frame completes", 20);
      begin
        repeat (40) @(posedge clk iff tick16);
        pulse(tx_dis);
      end
    join
    chk("R9 rdy off", tx_rdy, 0);
    wr(8'h00);
    repeat (3) @(negedge clk);
    chk("R8 ignored after disable", tx_emt, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule